// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block performs a masked gather of 32-bit elements into a vector destination. One operation takes a scalar base address, a vector of 32-bit or 64-bit signed indices, a 2-bit scale code, an optional displacement, a per-lane mask and the old destination value. It works through the active lanes one at a time. For each one it forms an address, issues a single read on a valid/ready request port, and merges the returned word into the destination lane.

The mask also records how far the operation has progressed. Every lane that is gathered clears its own mask lane. A read that comes back with a fault stops the sequence. The lanes gathered so far stay committed, and the faulting lane and every higher active lane keep their mask set. Issuing the operation again with the returned destination and mask therefore resumes the work at the point where it stopped. Lanes that carry no element are zeroed in both destination and mask, and this also happens when the very first read faults. A trap flag returned with a successful read is held. If a later read faults, the held trap is reported in place of that fault, together with a resume indication.

Top module: `gath_seq`

## Requirements
- R1: `start_i` is accepted only while `busy_o` is low. A start pulse, together with any change of the operand inputs, while an operation is running has no effect on that operation's result.
- R2: A lane is active only when bit 31 of its mask lane is 1. At acceptance each in-use mask lane becomes all ones (active) or all zeros (inactive), and this state can be observed in `mask_o` for lanes left unfinished after a fault.
- R3: The read address is `base + (signext(index) << scale_i) + disp`, computed modulo 2^64. `disp_sz_i` 00 gives no displacement, 01 gives `disp_i[7:0]` sign-extended, and 10 or 11 gives `disp_i[31:0]` sign-extended.
- R4: Active lanes are read in ascending lane order, starting at lane 0. Only one read is outstanding at a time. A request that is not yet accepted holds `req_valid_o` high with a stable `req_addr_o`.
- R5: An active lane receives the returned data. An inactive lane keeps its old destination value and issues no read.
- R6: The element count is 4 with 32-bit indices (`idx64_i`=0) in 128-bit mode (`wide_i`=0), 8 with 32-bit indices in 256-bit mode, 2 with 64-bit indices in 128-bit mode, and 4 with 64-bit indices in 256-bit mode. With 64-bit indices, lane k uses `index_i[64k+63:64k]`.
- R7: Destination and mask lanes at or above the element count are zero when the operation ends, whether it ends by completing or by faulting, and even when the fault hits the first read.
- R8: An operation that ends without a fault leaves `mask_o` all zero and `fault_o` low. `done_o` is a single-cycle pulse at the end of every operation.
- R9: When a read faults, no further reads are issued. Gathered lanes keep their data and have a cleared mask. The faulting lane and all higher active lanes keep an all-ones mask. `fault_o` is 1 and `fault_lane_o` gives the faulting lane.
- R10: If a trap was flagged on an earlier successful read and a later read faults, the block reports `trap_o`=1, `resume_o`=1 and `fault_o`=0. A trap with no fault reports `trap_o`=1 and `resume_o`=0.
- R11: Issuing the operation again with the returned `dest_o` and `mask_o` as inputs, with the fault removed, yields the same destination as a fault-free run of the original operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| wide_i | input | 1 | 1: 256-bit vector length, 0: 128-bit |
| idx64_i | input | 1 | 1: 64-bit indices, 0: 32-bit indices |
| scale_i | input | 2 | Index shift amount (scale 1, 2, 4, 8) |
| disp_sz_i | input | 2 | Displacement size code |
| disp_i | input | 32 | Displacement value |
| base_i | input | 64 | Scalar base address |
| index_i | input | 256 | Packed index vector |
| mask_i | input | 256 | Per-lane mask, 32 bits per lane |
| dest_i | input | 256 | Old destination value |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | 64 | Read byte address |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 32 | Read response data |
| rsp_fault_i | input | 1 | Read faulted |
| rsp_trap_i | input | 1 | Successful read raised a trap |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| fault_o | output | 1 | Operation stopped on a fault |
| trap_o | output | 1 | Trap reported |
| resume_o | output | 1 | Trap reported in place of a fault |
| fault_lane_o | output | 3 | Lane whose read faulted |
| dest_o | output | 256 | Updated destination |
| mask_o | output | 256 | Updated mask |

## Verification
The bench targets faults on the first lane with 64-bit indices. A design that zeroes unused lanes only on completion would leave stale upper bits there. It chains a faulting run into a resume run, which exposes a design that clears mask lanes before the data is committed or that rereads lanes already gathered. It places a trap ahead of a later fault, so swapped or missing priority shows up as the wrong status flags. Negative indices combined with every scale and displacement size catch addresses that are zero-extended or shifted wrongly. Out-of-order issue is caught by comparing the full request address log. A start pulse sent mid-operation with corrupted operands exposes a block that relatches its inputs while busy.

// File: rtl/gath_pkg.sv
// Shared types for the gather sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package gath_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] DSP_NONE = 2'b00;
    localparam logic [1:0] DSP_BYTE = 2'b01;
endpackage

// File: rtl/gath_idx_unpack.sv
// Index unpacker: turns the packed index vector into one sign-extended
// address-width offset per lane, for 32-bit or 64-bit index layouts.
// Assumes: 64-bit indices exist only for the lower half of the lanes.
module gath_idx_unpack #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 32,
    parameter int ADDR_W = 64
) (
    input  logic [LANES*ELEM_W-1:0]        idx_vec_i,
    input  logic                           idx64_i,
    output logic [LANES-1:0][ADDR_W-1:0]   lane_idx_o
);
    localparam int WIDE_W = 2 * ELEM_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [ELEM_W-1:0] narrow;
        logic signed [WIDE_W-1:0] wide;
        assign narrow = idx_vec_i[l*ELEM_W +: ELEM_W];
        if (l < LANES / 2) begin : g_has_wide
            assign wide = idx_vec_i[l*WIDE_W +: WIDE_W];
        end else begin : g_no_wide
            assign wide = '0;
        end
        // Select the lane's offset according to the index layout.
        assign lane_idx_o[l] = idx64_i ? ADDR_W'(wide) : ADDR_W'(narrow);
    end
endmodule

// File: rtl/gath_first_active.sv
// Priority picker: reports the lowest-numbered active lane.
// Assumes: act_i has one bit per lane; no clock.
module gath_first_active #(
    parameter int LANES  = 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  act_i,
    output logic              found_o,
    output logic [LANE_W-1:0] lane_o
);
    // Scan from the top so the lowest set lane wins.
    always_comb begin
        found_o = 1'b0;
        lane_o  = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (act_i[l]) begin
                found_o = 1'b1;
                lane_o  = LANE_W'(l);
            end
        end
    end
endmodule

// File: rtl/gath_addr_gen.sv
// Address generator: base + (offset << scale) + sign-extended displacement.
// Assumes: offset already sign-extended to the address width; wraps mod 2^ADDR_W.
module gath_addr_gen #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offs_i,
    input  logic [1:0]        scale_i,
    input  logic [1:0]        disp_sz_i,
    input  logic [31:0]       disp_i,
    output logic [ADDR_W-1:0] addr_o
);
    import gath_pkg::*;

    logic [ADDR_W-1:0] disp_ext;

    // Extend the displacement according to its size code.
    always_comb begin
        case (disp_sz_i)
            DSP_NONE: disp_ext = '0;
            DSP_BYTE: disp_ext = ADDR_W'($signed(disp_i[7:0]));
            default:  disp_ext = ADDR_W'($signed(disp_i));
        endcase
    end

    assign addr_o = base_i + (offs_i << scale_i) + disp_ext;
endmodule

// File: rtl/gath_seq.sv
// Masked gather sequencer top. Latches an operation on start, normalises the
// mask, zeroes unused lanes, then issues one read per active lane in
// ascending order and merges each result. A faulting read ends the run
// with partial results committed.
// Assumes: one request outstanding; responses arrive in order; ADDR_W == 2*ELEM_W.
module gath_seq #(
    parameter int MAX_LANES = 8,
    parameter int ELEM_W    = 32,
    parameter int ADDR_W    = 64,
    localparam int VEC_W    = MAX_LANES * ELEM_W,
    localparam int LANE_W   = $clog2(MAX_LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic              idx64_i,
    input  logic [1:0]        scale_i,
    input  logic [1:0]        disp_sz_i,
    input  logic [31:0]       disp_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [VEC_W-1:0]  index_i,
    input  logic [VEC_W-1:0]  mask_i,
    input  logic [VEC_W-1:0]  dest_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    input  logic [ELEM_W-1:0] rsp_data_i,
    input  logic              rsp_fault_i,
    input  logic              rsp_trap_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic              trap_o,
    output logic              resume_o,
    output logic [LANE_W-1:0] fault_lane_o,
    output logic [VEC_W-1:0]  dest_o,
    output logic [VEC_W-1:0]  mask_o
);
    import gath_pkg::*;

    localparam int CNT_W = LANE_W + 2;

    seq_state_e              state_q;
    logic                    wide_q, idx64_q;
    logic [1:0]              scale_q, dsz_q;
    logic [31:0]             disp_q;
    logic [ADDR_W-1:0]       base_q;
    logic [VEC_W-1:0]        index_q, dest_q, mask_q;
    logic                    done_q, fault_q, trap_q, resume_q, trap_pend_q;
    logic [LANE_W-1:0]       flane_q, cur_q;

    logic [CNT_W-1:0]        nelem_in, nelem_q;
    logic [VEC_W-1:0]        use_in_vec, use_q_vec;
    logic [VEC_W-1:0]        mask_load, dest_load;
    logic [MAX_LANES-1:0]    act;
    logic                    pick_found;
    logic [LANE_W-1:0]       pick_lane;
    logic [MAX_LANES-1:0][ADDR_W-1:0] lane_idx;

    // Element count for the requested and the latched mode.
    assign nelem_in = CNT_W'(wide_i  ? MAX_LANES : MAX_LANES / 2) >> idx64_i;
    assign nelem_q  = CNT_W'(wide_q  ? MAX_LANES : MAX_LANES / 2) >> idx64_q;

    // Per-lane in-use masks and the normalised load values.
    always_comb begin
        for (int l = 0; l < MAX_LANES; l++) begin
            use_in_vec[l*ELEM_W +: ELEM_W] = (CNT_W'(l) < nelem_in) ? '1 : '0;
            use_q_vec[l*ELEM_W +: ELEM_W]  = (CNT_W'(l) < nelem_q)  ? '1 : '0;
            mask_load[l*ELEM_W +: ELEM_W]  =
                ((CNT_W'(l) < nelem_in) && mask_i[l*ELEM_W + ELEM_W - 1]) ? '1 : '0;
        end
        dest_load = dest_i & use_in_vec;
    end

    // Active lanes are those whose mask MSB is still set.
    always_comb begin
        for (int l = 0; l < MAX_LANES; l++) begin
            act[l] = mask_q[l*ELEM_W + ELEM_W - 1];
        end
    end

    gath_first_active #(.LANES(MAX_LANES)) u_pick (
        .act_i   (act),
        .found_o (pick_found),
        .lane_o  (pick_lane)
    );

    gath_idx_unpack #(.LANES(MAX_LANES), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)) u_idx (
        .idx_vec_i  (index_q),
        .idx64_i    (idx64_q),
        .lane_idx_o (lane_idx)
    );

    gath_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .base_i    (base_q),
        .offs_i    (lane_idx[pick_lane]),
        .scale_i   (scale_q),
        .disp_sz_i (dsz_q),
        .disp_i    (disp_q),
        .addr_o    (req_addr_o)
    );

    assign req_valid_o  = (state_q == ST_ISSUE) && pick_found;
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign fault_o      = fault_q;
    assign trap_o       = trap_q;
    assign resume_o     = resume_q;
    assign fault_lane_o = flane_q;
    assign dest_o       = dest_q;
    assign mask_o       = mask_q;

    // Sequencer: latch, issue, wait for data, merge or stop on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wide_q      <= 1'b0;
            idx64_q     <= 1'b0;
            scale_q     <= '0;
            dsz_q       <= '0;
            disp_q      <= '0;
            base_q      <= '0;
            index_q     <= '0;
            dest_q      <= '0;
            mask_q      <= '0;
            done_q      <= 1'b0;
            fault_q     <= 1'b0;
            trap_q      <= 1'b0;
            resume_q    <= 1'b0;
            trap_pend_q <= 1'b0;
            flane_q     <= '0;
            cur_q       <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        wide_q      <= wide_i;
                        idx64_q     <= idx64_i;
                        scale_q     <= scale_i;
                        dsz_q       <= disp_sz_i;
                        disp_q      <= disp_i;
                        base_q      <= base_i;
                        index_q     <= index_i;
                        mask_q      <= mask_load;
                        dest_q      <= dest_load;
                        fault_q     <= 1'b0;
                        trap_q      <= 1'b0;
                        resume_q    <= 1'b0;
                        trap_pend_q <= 1'b0;
                        flane_q     <= '0;
                        state_q     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (!pick_found) begin
                        done_q  <= 1'b1;
                        trap_q  <= trap_pend_q;
                        state_q <= ST_IDLE;
                    end else if (req_ready_i) begin
                        cur_q   <= pick_lane;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid_i) begin
                        if (rsp_fault_i) begin
                            done_q   <= 1'b1;
                            flane_q  <= cur_q;
                            fault_q  <= !trap_pend_q;
                            trap_q   <= trap_pend_q;
                            resume_q <= trap_pend_q;
                            state_q  <= ST_IDLE;
                        end else begin
                            dest_q[cur_q*ELEM_W +: ELEM_W] <= rsp_data_i;
                            mask_q[cur_q*ELEM_W +: ELEM_W] <= '0;
                            trap_pend_q <= trap_pend_q | rsp_trap_i;
                            state_q     <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: a pending request holds its address until accepted.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

    // R4: an accepted request is not followed at once by another.
    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i |=> !req_valid_o);

    // R8: done lasts exactly one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a run that ends without fault leaves no mask bit set.
    p_clean_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !fault_o && !resume_o |-> mask_o == '0);

    // R7: lanes with no element stay zero while a run is in flight.
    p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((mask_q | dest_q) & ~use_q_vec) == '0);

    // R9: once a run has started, mask bits are only ever cleared.
    p_mask_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> (mask_q & ~$past(mask_q)) == '0);

    // R10: fault and trap are never reported together.
    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(fault_o && trap_o));
endmodule

// File: tb/gath_seq_tb_top.sv
// Self-checking bench for gath_seq: directed corners plus seeded random runs.
module gath_seq_tb_top;
    localparam int L  = 8;
    localparam int EW = 32;
    localparam int AW = 64;
    localparam int VW = L * EW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i, wide_i, idx64_i;
    logic [1:0]    scale_i, disp_sz_i;
    logic [31:0]   disp_i;
    logic [AW-1:0] base_i;
    logic [VW-1:0] index_i, mask_i, dest_i;
    logic          req_valid_o, req_ready_i;
    logic [AW-1:0] req_addr_o;
    logic          rsp_valid_i, rsp_fault_i, rsp_trap_i;
    logic [EW-1:0] rsp_data_i;
    logic          busy_o, done_o, fault_o, trap_o, resume_o;
    logic [2:0]    fault_lane_o;
    logic [VW-1:0] dest_o, mask_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Fault/trap injection and request log.
    bit            f_en, t_en;
    logic [AW-1:0] f_addr, t_addr;
    logic [AW-1:0] req_log [0:15];
    int            req_cnt;

    // Expected results.
    logic [VW-1:0] e_dest, e_mask;
    logic          e_fault, e_trap, e_resume;
    int            e_lane, e_n;
    logic [AW-1:0] e_addr [0:15];

    always #2 clk = ~clk;

    gath_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .idx64_i(idx64_i), .scale_i(scale_i), .disp_sz_i(disp_sz_i),
        .disp_i(disp_i), .base_i(base_i), .index_i(index_i), .mask_i(mask_i),
        .dest_i(dest_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i),
        .rsp_data_i(rsp_data_i), .rsp_fault_i(rsp_fault_i),
        .rsp_trap_i(rsp_trap_i), .busy_o(busy_o), .done_o(done_o),
        .fault_o(fault_o), .trap_o(trap_o), .resume_o(resume_o),
        .fault_lane_o(fault_lane_o), .dest_o(dest_o), .mask_o(mask_o)
    );

    function automatic logic [31:0] memf(logic [AW-1:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [AW-1:0] lane_addr(int l);
        logic [AW-1:0] off, d;
        if (idx64_i) off = index_i[l*64 +: 64];
        else         off = AW'($signed(index_i[l*32 +: 32]));
        case (disp_sz_i)
            2'b00:   d = '0;
            2'b01:   d = AW'($signed(disp_i[7:0]));
            default: d = AW'($signed(disp_i));
        endcase
        return base_i + (off << scale_i) + d;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model();
        int n;
        bit tp;
        logic [AW-1:0] a;
        n = ((wide_i ? 8 : 4) >> idx64_i);
        e_dest = '0; e_mask = '0;
        e_fault = 0; e_trap = 0; e_resume = 0; e_lane = 0; e_n = 0; tp = 0;
        for (int l = 0; l < n; l++) begin
            e_dest[l*32 +: 32] = dest_i[l*32 +: 32];
            e_mask[l*32 +: 32] = mask_i[l*32 + 31] ? '1 : '0;
        end
        for (int l = 0; l < n; l++) begin
            if (e_mask[l*32 + 31]) begin
                a = lane_addr(l);
                e_addr[e_n] = a;
                e_n++;
                if (f_en && a == f_addr) begin
                    e_lane = l;
                    if (tp) begin e_trap = 1; e_resume = 1; end
                    else e_fault = 1;
                    return;
                end
                e_dest[l*32 +: 32] = memf(a);
                e_mask[l*32 +: 32] = '0;
                if (t_en && a == t_addr) tp = 1;
            end
        end
        e_trap = tp;
    endtask

    // Memory responder with random stalls and latency.
    initial begin
        logic [AW-1:0] a;
        req_ready_i = 0; rsp_valid_i = 0; rsp_data_i = '0;
        rsp_fault_i = 0; rsp_trap_i = 0;
        forever begin
            @(negedge clk);
            rsp_valid_i = 0; rsp_fault_i = 0; rsp_trap_i = 0; req_ready_i = 0;
            if (req_valid_o && ($urandom % 3 != 0)) begin
                req_ready_i = 1;
                a = req_addr_o;
                if (req_cnt < 16) req_log[req_cnt] = a;
                req_cnt++;
                @(negedge clk);
                req_ready_i = 0;
                repeat ($urandom % 3) @(negedge clk);
                rsp_valid_i = 1;
                rsp_data_i  = memf(a);
                rsp_fault_i = f_en && (a == f_addr);
                rsp_trap_i  = t_en && (a == t_addr);
            end
        end
    end

    // Run one operation with the current inputs; optionally poke start mid-run.
    task automatic run_op(bit inject, string tag);
        logic [VW-1:0] sm, sd;
        logic [AW-1:0] sb;
        int guard;
        model();
        req_cnt = 0;
        @(negedge clk);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        if (inject) begin
            sm = mask_i; sd = dest_i; sb = base_i;
            start_i = 1; mask_i = ~mask_i; dest_i = ~dest_i; base_i = ~base_i;
            @(negedge clk);
            start_i = 0; mask_i = sm; dest_i = sd; base_i = sb;
        end
        guard = 0;
        while (!done_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_o, tag, "done seen", VW'(done_o), VW'(1));
        chk(dest_o == e_dest, tag, "dest", dest_o, e_dest);
        chk(mask_o == e_mask, tag, "mask", mask_o, e_mask);
        chk({fault_o, trap_o, resume_o} == {e_fault, e_trap, e_resume}, tag,
            "fault/trap/resume", VW'({fault_o, trap_o, resume_o}), VW'({e_fault, e_trap, e_resume}));
        if (e_fault || e_resume)
            chk(fault_lane_o == 3'(e_lane), tag, "fault lane", VW'(fault_lane_o), VW'(e_lane));
        chk(req_cnt == e_n, tag, "request count", VW'(req_cnt), VW'(e_n));
        for (int k = 0; k < e_n && k < req_cnt && k < 16; k++)
            chk(req_log[k] == e_addr[k], tag, "request address order", VW'(req_log[k]), VW'(e_addr[k]));
        @(negedge clk);
        chk(!done_o && !busy_o, tag, "done pulse ends, idle", VW'({done_o, busy_o}), VW'(0));
    endtask

    task automatic rnd_inputs();
        wide_i = 1'($urandom); idx64_i = 1'($urandom);
        scale_i = 2'($urandom); disp_sz_i = 2'($urandom); disp_i = $urandom;
        base_i = {$urandom, $urandom};
        for (int l = 0; l < 8; l++) begin
            index_i[l*32 +: 32] = $urandom;
            mask_i[l*32 +: 32]  = $urandom;
            dest_i[l*32 +: 32]  = $urandom;
        end
        f_en = 0; t_en = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] sav_dest;
        void'($urandom(32'd20240611));
        rst_n = 0; start_i = 0; wide_i = 0; idx64_i = 0; scale_i = 0;
        disp_sz_i = 0; disp_i = 0; base_i = 0; index_i = 0; mask_i = 0;
        dest_i = 0; f_en = 0; t_en = 0; f_addr = 0; t_addr = 0; req_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o && !req_valid_o && mask_o == '0 && dest_o == '0,
            "reset", "idle outputs", VW'({busy_o, done_o, req_valid_o}), VW'(0));

        // R5 R8: no active lane leaves destination untouched, issues no read.
        rnd_inputs(); wide_i = 1; idx64_i = 0;
        for (int l = 0; l < 8; l++) mask_i[l*32 + 31] = 1'b0;
        run_op(0, "R5_R8_all_inactive");

        // R3: negative index, max scale, byte displacement.
        rnd_inputs(); wide_i = 1; idx64_i = 0; scale_i = 2'd3; disp_sz_i = 2'b01;
        disp_i = 32'h1234_5680; index_i[31:0] = 32'hFFFF_FFF0; mask_i = '1;
        run_op(0, "R3_neg_idx_byte_disp");
        rnd_inputs(); disp_sz_i = 2'b00; mask_i = '1;
        run_op(0, "R3_no_disp");
        rnd_inputs(); disp_sz_i = 2'b10; disp_i = 32'h8000_0004; mask_i = '1; idx64_i = 1;
        run_op(0, "R3_R6_dword_disp_idx64");

        // R6 R7 R9: first lane faults with 64-bit indices, 128-bit mode.
        rnd_inputs(); wide_i = 0; idx64_i = 1; mask_i = '1;
        f_en = 1; f_addr = lane_addr(0);
        run_op(0, "R7_R9_fault_first_lane");

        // R2 R9 R11: fault mid-way, then resume.
        rnd_inputs(); wide_i = 1; idx64_i = 0; mask_i = '1; mask_i[95] = 1'b0;
        f_en = 0; model(); sav_dest = e_dest;
        f_en = 1; f_addr = lane_addr(5);
        run_op(0, "R2_R9_fault_lane5");
        chk(mask_o[5*32 +: 32] == '1 && mask_o[2*32 +: 32] == '0, "R2",
            "normalised mask after fault", mask_o, e_mask);
        dest_i = dest_o; mask_i = mask_o; f_en = 0;
        run_op(0, "R11_resume");
        chk(dest_o == sav_dest, "R11", "resumed result", dest_o, sav_dest);

        // R10: trap on lane 1, fault on lane 3.
        rnd_inputs(); wide_i = 1; idx64_i = 0; mask_i = '1;
        t_en = 1; t_addr = lane_addr(1); f_en = 1; f_addr = lane_addr(3);
        run_op(0, "R10_trap_then_fault");
        rnd_inputs(); wide_i = 0; idx64_i = 0; mask_i = '1;
        t_en = 1; t_addr = lane_addr(2);
        run_op(0, "R10_trap_only");

        // R1: start pulse with corrupted operands while busy.
        rnd_inputs(); mask_i[31] = 1'b1;
        run_op(1, "R1_start_while_busy");

        // R4 R5 R6 R8 R9 R10: random mix.
        for (int it = 0; it < 250; it++) begin
            int n;
            rnd_inputs();
            n = (wide_i ? 8 : 4) >> idx64_i;
            if ($urandom % 3 == 0) begin f_en = 1; f_addr = lane_addr($urandom % n); end
            if ($urandom % 4 == 0) begin t_en = 1; t_addr = lane_addr($urandom % n); end
            run_op(0, "R4_R6_random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule